// File: doc/BRIEF.md
# Interlocked Board Control Register File

This block is a small bank of byte-wide registers on a board's local bus. Software uses it to set the board-level controls: serial-link deskew and DC-balance mode, ADC power, a front-panel LED, four shared crate-status drive lines, two outgoing signal lines and the serial DAC chip select. Through the same bank it reads back the FPGA status nibbles, the backplane crate-status lines and the data bit that returns from the end of the serial DAC chain. A register is picked by four local address bits, which are bits 4..1 of the local address. A read multiplexer places the addressed register on the read data bus in the same cycle.

Hazardous actions are interlocked. Their enable bits sit in a different register from the bits that perform them, so a single corrupted write cannot both arm an action and carry it out. Writing to a data-less port address shifts one bit into the DAC chain. The write sets the serial data line and sends a single clock pulse to the chain, but only while loading is enabled.

Top module: `board_ctrl_regs`

## Requirements
- R1: After synchronous reset every control bit is 0. So deskew_n=0, dc_bal=0, led_n=1, cfg_en=0, dac_load_en=0, dbg_oe=0, adc_en=0, crate_drv=0, sig_out=0, dac_cs_n=1, dac_sclk=0 and dac_sdata=0.
- R2: bus_addr decodes as follows: 0 = control A, 1 = control B, 2 = status A, 3 = status B, 4 = DAC shift port. Values 5 to 15 are unused. A write (bus_wr high at a rising edge) to address 0 or 1 changes the register and its outputs right after that edge.
- R3: Control A bit layout:
  - bit0 drives deskew_n (0 runs deskew)
  - bit1 drives dc_bal
  - bit3 is the LED control; led_n is its inverse
  - bit4 drives cfg_en
  - bit5 drives dac_load_en
  - bit6 drives dbg_oe
  - bit7 drives adc_en
  - bit2 holds nothing and reads 0
- R4: Control B bit layout:
  - bits 3..0 drive crate_drv[3:0]
  - bits 5..4 drive sig_out[1:0]
  - bit6 is the DAC select request
  - bit7 holds nothing and reads 0
- R5: dac_cs_n is 0 only when dac_load_en is 1 and the select request bit (control B bit6) is 0. In every other case it is 1.
- R6: A write to address 4 while dac_load_en is 1 is accepted. After that edge dac_sdata equals bus_wdata[0]. dac_sclk is then high for exactly one cycle, starting one cycle later, so the data is stable for one cycle before the rising edge.
- R7: A write to address 4 while dac_load_en is 0 has no effect: dac_sdata keeps its value and no clock pulse is produced.
- R8: A write to address 4 while a clock pulse is still pending or high is dropped. Both dac_sdata and the pulse count are left unchanged.
- R9: Status A reads fpga0_stat in bits 3..0 and fpga1_stat in bits 7..4.
- R10: Status B reads the inverse of bp_status_n in bits 3..0 and dac_sdo_in in bit4. Bits 7..5 read 0.
- R11: Reads of address 4 and of addresses 5 to 15 return 0x00. Writes to those addresses and to the status addresses change no register or output.
- R12: bus_rdata is combinational: it reflects bus_addr and the register contents in the same cycle, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register select, local address bits 4..1 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| fpga0_stat | input | 4 | Status nibble from FPGA 0 |
| fpga1_stat | input | 4 | Status nibble from FPGA 1 |
| bp_status_n | input | 4 | Backplane crate-status lines, active low |
| dac_sdo_in | input | 1 | Serial output of the last DAC in the chain |
| deskew_n | output | 1 | Serial link deskew, low runs deskew |
| dc_bal | output | 1 | Serial link DC-balance mode |
| adc_en | output | 1 | ADC enable, low powers down |
| led_n | output | 1 | Front-panel LED, active low |
| cfg_en | output | 1 | FPGA configuration enable |
| dac_load_en | output | 1 | DAC loading enable |
| dbg_oe | output | 1 | Debug port output enable |
| crate_drv | output | 4 | Crate-status line drive, 1 pulls line active |
| sig_out | output | 2 | Two outgoing signal lines |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_sdata | output | 1 | Serial data to the first DAC |
| dac_sclk | output | 1 | DAC serial clock, DAC samples on rising edge |

## Verification
Read data is due in the same cycle as the address, so the bench sets the address at a falling edge and samples shortly after. Control outputs are due right after the edge that samples the write strobe, and the bench checks them at the next falling edge. For a DAC port write, the data line is checked at the falling edge after the strobe edge. The clock is checked low there, high one falling edge later and low again at the one after that. The bench counts high samples over a fixed window, which catches missing, doubled or stretched pulses. Dropped and disabled writes are judged through dac_sdata and that same pulse count.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NIB_W  = 4;
  localparam int NREG_RW = 2;

  localparam logic [ADDR_W-1:0] A_CTRL_A = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_B = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT_A = 4'd2;
  localparam logic [ADDR_W-1:0] A_STAT_B = 4'd3;
  localparam logic [ADDR_W-1:0] A_DACPRT = 4'd4;

  // control A field positions
  localparam int CA_DESKEW = 0;
  localparam int CA_DCBAL  = 1;
  localparam int CA_LED    = 3;
  localparam int CA_CFGEN  = 4;
  localparam int CA_DACEN  = 5;
  localparam int CA_DBGOE  = 6;
  localparam int CA_ADCEN  = 7;
  // control B field positions
  localparam int CB_CRATE  = 0;
  localparam int CB_SIG    = 4;
  localparam int CB_CSREQ  = 6;
  // status B field positions
  localparam int SB_DACRB  = 4;

  localparam logic [DATA_W-1:0] CTRL_A_MASK = 8'b1111_1011;
  localparam logic [DATA_W-1:0] CTRL_B_MASK = 8'b0111_1111;

  // chip select is asserted (low) only if loading enabled and request low
  function automatic logic cs_level(input logic load_en, input logic req_bit);
    return !(load_en && !req_bit);
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat_b(input logic [NIB_W-1:0] lines_n,
                                                    input logic rb);
    logic [DATA_W-1:0] v;
    v = '0;
    v[NIB_W-1:0] = ~lines_n;
    v[SB_DACRB] = rb;
    return v;
  endfunction
endpackage

// File: rtl/bc_ctrl_bank.sv
module bc_ctrl_bank
  import board_ctrl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NREG_RW-1:0]            wr_sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG_RW-1:0][DATA_W-1:0] regs_q
);
  localparam logic [NREG_RW-1:0][DATA_W-1:0] MASKS = {CTRL_B_MASK, CTRL_A_MASK};

  for (genvar g = 0; g < NREG_RW; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (wr_sel[g]) regs_q[g] <= wdata & MASKS[g];
    end
  end
endmodule

// File: rtl/bc_dac_port.sv
module bc_dac_port (
  input  logic clk,
  input  logic rst,
  input  logic port_wr,
  input  logic load_en,
  input  logic din,
  output logic sdata,
  output logic sclk,
  output logic busy
);
  logic armed;
  logic accept;

  assign busy   = armed | sclk;
  assign accept = port_wr & load_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata <= 1'b0;
      armed <= 1'b0;
      sclk  <= 1'b0;
    end else begin
      if (accept) sdata <= din;
      armed <= accept;
      sclk  <= armed;
    end
  end
endmodule

// File: rtl/bc_read_mux.sv
module bc_read_mux
  import board_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_a,
  input  logic [DATA_W-1:0] ctrl_b,
  input  logic [DATA_W-1:0] stat_a,
  input  logic [DATA_W-1:0] stat_b,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    case (addr)
      A_CTRL_A: rdata = ctrl_a;
      A_CTRL_B: rdata = ctrl_b;
      A_STAT_A: rdata = stat_a;
      A_STAT_B: rdata = stat_b;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NIB_W-1:0]  fpga0_stat,
  input  logic [NIB_W-1:0]  fpga1_stat,
  input  logic [NIB_W-1:0]  bp_status_n,
  input  logic              dac_sdo_in,
  output logic              deskew_n,
  output logic              dc_bal,
  output logic              adc_en,
  output logic              led_n,
  output logic              cfg_en,
  output logic              dac_load_en,
  output logic              dbg_oe,
  output logic [NIB_W-1:0]  crate_drv,
  output logic [1:0]        sig_out,
  output logic              dac_cs_n,
  output logic              dac_sdata,
  output logic              dac_sclk
);
  logic [NREG_RW-1:0]             wr_sel;
  logic [NREG_RW-1:0][DATA_W-1:0] regs_q;
  logic                           port_wr;
  logic                           port_busy;
  logic [DATA_W-1:0]              stat_a;
  logic [DATA_W-1:0]              stat_b;

  assign wr_sel[0] = bus_wr && (bus_addr == A_CTRL_A);
  assign wr_sel[1] = bus_wr && (bus_addr == A_CTRL_B);
  assign port_wr   = bus_wr && (bus_addr == A_DACPRT);

  bc_ctrl_bank u_bank (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(bus_wdata), .regs_q(regs_q)
  );

  bc_dac_port u_port (
    .clk(clk), .rst(rst), .port_wr(port_wr), .load_en(dac_load_en),
    .din(bus_wdata[0]), .sdata(dac_sdata), .sclk(dac_sclk), .busy(port_busy)
  );

  assign stat_a = {fpga1_stat, fpga0_stat};
  assign stat_b = pack_stat_b(bp_status_n, dac_sdo_in);

  bc_read_mux u_mux (
    .addr(bus_addr), .ctrl_a(regs_q[0]), .ctrl_b(regs_q[1]),
    .stat_a(stat_a), .stat_b(stat_b), .rdata(bus_rdata)
  );

  assign deskew_n    = regs_q[0][CA_DESKEW];
  assign dc_bal      = regs_q[0][CA_DCBAL];
  assign led_n       = ~regs_q[0][CA_LED];
  assign cfg_en      = regs_q[0][CA_CFGEN];
  assign dac_load_en = regs_q[0][CA_DACEN];
  assign dbg_oe      = regs_q[0][CA_DBGOE];
  assign adc_en      = regs_q[0][CA_ADCEN];
  assign crate_drv   = regs_q[1][CB_CRATE +: NIB_W];
  assign sig_out     = regs_q[1][CB_SIG +: 2];
  assign dac_cs_n    = cs_level(dac_load_en, regs_q[1][CB_CSREQ]);
endmodule

// File: rtl/bc_regs_chk.sv
module bc_regs_chk
  import board_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NIB_W-1:0]  bp_status_n,
  input logic              dac_load_en,
  input logic              dac_cs_n,
  input logic              dac_sclk,
  input logic              dac_sdata,
  input logic              port_busy,
  input logic              adc_en
);
  AST_CS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) !dac_load_en |-> dac_cs_n); // R5
  AST_SCLK_SINGLE: assert property (@(posedge clk) disable iff (rst) $rose(dac_sclk) |=> !dac_sclk); // R6
  AST_SDATA_SETUP: assert property (@(posedge clk) disable iff (rst) $rose(dac_sclk) |-> $stable(dac_sdata)); // R6
  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DACPRT && !dac_load_en && !port_busy) |-> ##2 !dac_sclk); // R7
  AST_BUSY_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst) port_busy |=> $stable(dac_sdata)); // R8
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= A_DACPRT) |-> bus_rdata == '0); // R11
  AST_STAT_B_INVERT: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STAT_B) |-> bus_rdata[NIB_W-1:0] == ~bp_status_n); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) !bus_wr |=> $stable(adc_en)); // R2
endmodule

bind board_ctrl_regs bc_regs_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .bp_status_n(bp_status_n), .dac_load_en(dac_load_en), .dac_cs_n(dac_cs_n),
  .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .port_busy(port_busy), .adc_en(adc_en)
);

// File: tb/tb_board_ctrl_regs.sv
`timescale 1ns/1ps
module tb_board_ctrl_regs;
  logic clk = 1'b0;
  logic rst;
  logic [3:0] bus_addr;
  logic bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] fpga0_stat, fpga1_stat, bp_status_n;
  logic dac_sdo_in;
  logic deskew_n, dc_bal, adc_en, led_n, cfg_en, dac_load_en, dbg_oe;
  logic [3:0] crate_drv;
  logic [1:0] sig_out;
  logic dac_cs_n, dac_sdata, dac_sclk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  board_ctrl_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp, "read");
  endtask

  task automatic t_reset;
    chk("R1", {deskew_n, dc_bal, led_n, cfg_en, dac_load_en, dbg_oe, adc_en},
        7'b0010000, "ctrl A outputs");
    chk("R1", {crate_drv, sig_out, dac_cs_n, dac_sclk, dac_sdata}, 9'b000000100,
        "ctrl B and DAC outputs");
    rd_chk("R1", 4'd0, 8'h00);
    rd_chk("R1", 4'd1, 8'h00);
  endtask

  task automatic t_ctrl_a;
    wr(4'd0, 8'hFF);
    chk("R3", {deskew_n, dc_bal, led_n, cfg_en, dac_load_en, dbg_oe, adc_en},
        7'b1101111, "ctrl A all ones");
    rd_chk("R3", 4'd0, 8'hFB);
    wr(4'd0, 8'h89);
    chk("R3", {deskew_n, dc_bal, led_n, cfg_en, dac_load_en, dbg_oe, adc_en},
        7'b1000001, "ctrl A 0x89");
    rd_chk("R2", 4'd0, 8'h89);
  endtask

  task automatic t_ctrl_b;
    wr(4'd1, 8'hFF);
    chk("R4", {crate_drv, sig_out}, 6'h3F, "ctrl B all ones");
    rd_chk("R4", 4'd1, 8'h7F);
    wr(4'd1, 8'h25);
    chk("R4", {crate_drv, sig_out}, {4'h5, 2'b10}, "ctrl B 0x25");
  endtask

  task automatic t_cs;
    wr(4'd0, 8'h00); wr(4'd1, 8'h00);
    chk("R5", dac_cs_n, 1'b1, "req low, enable off");
    wr(4'd0, 8'h20);
    chk("R5", dac_cs_n, 1'b0, "req low, enable on");
    wr(4'd1, 8'h40);
    chk("R5", dac_cs_n, 1'b1, "req high, enable on");
    wr(4'd0, 8'h00);
    chk("R5", dac_cs_n, 1'b1, "req high, enable off");
  endtask

  task automatic t_dac_shift(input logic b);
    int highs = 0;
    @(negedge clk);
    bus_addr = 4'd4; bus_wdata = {7'h55, b}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R6", {dac_sdata, dac_sclk}, {b, 1'b0}, "data set, clock low");
    @(negedge clk);
    chk("R6", {dac_sdata, dac_sclk}, {b, 1'b1}, "clock high");
    @(negedge clk);
    chk("R6", dac_sclk, 1'b0, "clock low again");
    for (int i = 0; i < 3; i++) begin @(negedge clk); highs += dac_sclk; end
    chk("R6", highs, 0, "no extra pulse");
  endtask

  task automatic t_dac_disabled;
    int highs = 0;
    logic prev;
    wr(4'd0, 8'h00);
    prev = dac_sdata;
    @(negedge clk);
    bus_addr = 4'd4; bus_wdata = {7'h0, ~prev}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin highs += dac_sclk; @(negedge clk); end
    chk("R7", highs, 0, "pulses while disabled");
    chk("R7", dac_sdata, prev, "data while disabled");
  endtask

  task automatic t_dac_busy;
    int highs = 0;
    wr(4'd0, 8'h20);
    @(negedge clk);
    bus_addr = 4'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    bus_wdata = 8'h00;
    @(negedge clk);
    highs += dac_sclk;
    bus_wr = 1'b0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); highs += dac_sclk; end
    chk("R8", highs, 1, "pulse count with busy write");
    chk("R8", dac_sdata, 1'b1, "data kept with busy write");
  endtask

  task automatic t_status;
    @(negedge clk);
    fpga0_stat = 4'h3; fpga1_stat = 4'hC; bp_status_n = 4'b1010; dac_sdo_in = 1'b1;
    rd_chk("R9", 4'd2, 8'hC3);
    rd_chk("R10", 4'd3, 8'h15);
    @(negedge clk);
    fpga0_stat = 4'hA; fpga1_stat = 4'h5; bp_status_n = 4'b0000; dac_sdo_in = 1'b0;
    rd_chk("R12", 4'd2, 8'h5A);
    rd_chk("R10", 4'd3, 8'h0F);
  endtask

  task automatic t_unused;
    wr(4'd0, 8'h80); wr(4'd1, 8'h12);
    for (int a = 5; a < 16; a++) wr(a[3:0], 8'hFF);
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    rd_chk("R11", 4'd0, 8'h80);
    rd_chk("R11", 4'd1, 8'h12);
    chk("R11", {adc_en, dac_load_en, crate_drv, sig_out}, {2'b10, 4'h2, 2'b01}, "outputs kept");
    rd_chk("R11", 4'd4, 8'h00);
    rd_chk("R11", 4'd9, 8'h00);
    rd_chk("R11", 4'd15, 8'h00);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    fpga0_stat = '0; fpga1_stat = '0; bp_status_n = 4'hF; dac_sdo_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_a();
    t_ctrl_b();
    t_cs();
    wr(4'd0, 8'h20);
    t_dac_shift(1'b1);
    t_dac_shift(1'b0);
    t_dac_disabled();
    t_dac_busy();
    t_status();
    t_unused();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule